// File: doc/BRIEF.md
# Slave Image Expansion Window Decoder

This block sits behind a bus slave window and decides, for each incoming access, whether the target is local DRAM or an expansion module. The access arrives as an offset into the slave image, together with a valid strobe and a 4-bit code giving the image size. A code of n means an image of 2^(n+12) bytes. A one-bit control register holds an active-low expansion enable. It is written through a simple write strobe and is cleared by reset.

The expansion module takes over the upper half of each 32 MB region, where offset bit 24 is set. This happens only when three conditions hold together: the enable bit is 0, offset bit 24 is 1, and the size code is 0xD (32 MB) or larger. In every other case the whole image goes to DRAM. An offset beyond the programmed image selects neither target.

Routing is combinational from the offset, the size code and the stored enable bit. Each select, and the offset forwarded to its target, is forced low when the access is not valid.

Top module: `xwin_decoder`

## Requirements
- R1: After reset the stored disable bit is 0, so an in-image access with offset bit 24 set and a size code of 0xD or more selects the expansion module.
- R2: A cycle with `cfgWrEn` high loads `cfgExpDis` into the stored disable bit at that clock edge. Routing uses the new value from the next cycle on. Without a write strobe the bit holds its value.
- R3: An access whose offset is at or above 2^(sizeCode+12) asserts neither `dramSel` nor `expSel`.
- R4: `expSel` is 1 exactly when `accValid` is 1, the offset is inside the image, the stored disable bit is 0, offset bit 24 is 1 and `sizeCode` >= 0xD.
- R5: A valid in-image access that does not meet the R4 condition asserts `dramSel`. This covers a set disable bit, offset bit 24 clear, or a size code below 0xD.
- R6: `dramSel` and `expSel` are never high together, and both are 0 while `accValid` is 0.
- R7: When `expSel` is 1, `expOffset` equals offset bits [23:0]. When `dramSel` is 1, `dramOffset` equals the full offset. Each offset output is 0 while its select is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control bit |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the control bit |
| cfgExpDis | input | 1 | Value to store; 1 disables expansion access |
| accValid | input | 1 | An access is pending |
| accAddr | input | ADDR_W (32) | Offset of the access within the slave image |
| sizeCode | input | 4 | Slave image size code; image is 2^(code+12) bytes |
| dramSel | output | 1 | Access routed to DRAM |
| expSel | output | 1 | Access routed to the expansion module |
| dramOffset | output | ADDR_W (32) | Offset forwarded to DRAM |
| expOffset | output | EXP_BIT (24) | Offset forwarded to the expansion module |

## Verification
The only state is the disable bit. If it is wrong, every access in the upper half of a large enough image goes to the wrong target, and this shows in the first valid access after the reset or the write that set it. The select and offset paths are combinational, so a decode error shows in the same cycle as the offending offset and size code. For that reason the sweep covers every size code, both enable states, and offsets on each side of every power-of-two boundary.

// File: rtl/xwin_pkg.sv
package xwin_pkg;
  // Decode outcome passed from control to datapath
  typedef struct packed {
    logic dramHit;
    logic expHit;
  } xwin_strobe_t;

  localparam int unsigned XWIN_CODE_W = 4;
endpackage

// File: rtl/xwin_cfg_reg.sv
module xwin_cfg_reg (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrData,
  output logic expDisQ
);
  // Active-low expansion enable: reset value 0 allows expansion access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     expDisQ <= 1'b0;
    else if (wrEn) expDisQ <= wrData;
  end
endmodule

// File: rtl/xwin_ctrl.sv
module xwin_ctrl
  import xwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CODE_W    = XWIN_CODE_W,
  parameter int unsigned SIZE_BASE = 12,
  parameter int unsigned EXP_BIT   = 24,
  parameter int unsigned MIN_CODE  = 13
) (
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [CODE_W-1:0] sizeCode,
  input  logic              expDis,
  output xwin_strobe_t      strobe
);
  localparam int unsigned LIM_W = ADDR_W + 1;

  logic [LIM_W-1:0] imageLimit;
  logic             shiftTooWide;
  logic             inImage;
  logic             sizeOk;
  logic             expWindow;

  always_comb begin
    shiftTooWide = (int'(sizeCode) + int'(SIZE_BASE)) > int'(ADDR_W);
    imageLimit   = LIM_W'(1) << (int'(sizeCode) + int'(SIZE_BASE));
    inImage      = shiftTooWide || ({1'b0, accAddr} < imageLimit);
  end

  assign sizeOk    = int'(sizeCode) >= int'(MIN_CODE);
  assign expWindow = !expDis && sizeOk && accAddr[EXP_BIT];

  always_comb begin
    strobe.expHit  = accValid && inImage && expWindow;
    strobe.dramHit = accValid && inImage && !expWindow;
  end
endmodule

// File: rtl/xwin_dpath.sv
module xwin_dpath
  import xwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned EXP_BIT   = 24,
  parameter bit          ZERO_IDLE = 1'b1
) (
  input  logic [ADDR_W-1:0]  accAddr,
  input  xwin_strobe_t       strobe,
  output logic               dramSel,
  output logic               expSel,
  output logic [ADDR_W-1:0]  dramOffset,
  output logic [EXP_BIT-1:0] expOffset
);
  assign dramSel = strobe.dramHit;
  assign expSel  = strobe.expHit;

  generate
    if (ZERO_IDLE) begin : g_gated
      assign dramOffset = strobe.dramHit ? accAddr : '0;
      assign expOffset  = strobe.expHit ? accAddr[EXP_BIT-1:0] : '0;
    end else begin : g_pass
      assign dramOffset = accAddr;
      assign expOffset  = accAddr[EXP_BIT-1:0];
    end
  endgenerate
endmodule

// File: rtl/xwin_decoder.sv
module xwin_decoder
  import xwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_BASE = 12,
  parameter int unsigned EXP_BIT   = 24,
  parameter int unsigned MIN_CODE  = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic                   cfgExpDis,
  input  logic                   accValid,
  input  logic [ADDR_W-1:0]      accAddr,
  input  logic [XWIN_CODE_W-1:0] sizeCode,
  output logic                   dramSel,
  output logic                   expSel,
  output logic [ADDR_W-1:0]      dramOffset,
  output logic [EXP_BIT-1:0]     expOffset
);
  logic         expDisQ;
  xwin_strobe_t strobe;

  xwin_cfg_reg u_cfg (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (cfgWrEn),
    .wrData  (cfgExpDis),
    .expDisQ (expDisQ)
  );

  xwin_ctrl #(
    .ADDR_W    (ADDR_W),
    .CODE_W    (XWIN_CODE_W),
    .SIZE_BASE (SIZE_BASE),
    .EXP_BIT   (EXP_BIT),
    .MIN_CODE  (MIN_CODE)
  ) u_ctrl (
    .accValid (accValid),
    .accAddr  (accAddr),
    .sizeCode (sizeCode),
    .expDis   (expDisQ),
    .strobe   (strobe)
  );

  xwin_dpath #(
    .ADDR_W    (ADDR_W),
    .EXP_BIT   (EXP_BIT),
    .ZERO_IDLE (1'b1)
  ) u_dpath (
    .accAddr    (accAddr),
    .strobe     (strobe),
    .dramSel    (dramSel),
    .expSel     (expSel),
    .dramOffset (dramOffset),
    .expOffset  (expOffset)
  );
endmodule

// File: rtl/xwin_decoder_chk.sv
module xwin_decoder_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned EXP_BIT = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic               cfgExpDis,
  input logic               accValid,
  input logic [ADDR_W-1:0]  accAddr,
  input logic               dramSel,
  input logic               expSel,
  input logic [ADDR_W-1:0]  dramOffset,
  input logic [EXP_BIT-1:0] expOffset,
  input logic               expDisQ
);
  a_r1_reset_enables: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !expDisQ);

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (expDisQ == $past(cfgExpDis)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(expDisQ));

  a_r4_exp_needs_bit: assert property (@(posedge clk) disable iff (!rstN)
    expSel |-> (accAddr[EXP_BIT] && !expDisQ));

  a_r5_disabled_no_exp: assert property (@(posedge clk) disable iff (!rstN)
    expDisQ |-> !expSel);

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dramSel, expSel}));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!dramSel && !expSel));

  a_r7_exp_offset: assert property (@(posedge clk) disable iff (!rstN)
    expSel |-> (expOffset == accAddr[EXP_BIT-1:0]));

  a_r7_dram_offset: assert property (@(posedge clk) disable iff (!rstN)
    dramSel |-> (dramOffset == accAddr));

  a_r7_idle_offsets: assert property (@(posedge clk) disable iff (!rstN)
    (!dramSel && !expSel) |-> (dramOffset == '0 && expOffset == '0));
endmodule

bind xwin_decoder xwin_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .EXP_BIT (EXP_BIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgExpDis  (cfgExpDis),
  .accValid   (accValid),
  .accAddr    (accAddr),
  .dramSel    (dramSel),
  .expSel     (expSel),
  .dramOffset (dramOffset),
  .expOffset  (expOffset),
  .expDisQ    (expDisQ)
);

// File: tb/xwin_decoder_tb.sv
module xwin_decoder_tb;
  localparam int ADDR_W  = 32;
  localparam int EXP_BIT = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgExpDis = 1'b0;
  logic              accValid = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [3:0]        sizeCode = '0;
  logic              dramSel, expSel;
  logic [ADDR_W-1:0] dramOffset;
  logic [EXP_BIT-1:0] expOffset;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  xwin_decoder u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgExpDis(cfgExpDis),
    .accValid(accValid), .accAddr(accAddr), .sizeCode(sizeCode),
    .dramSel(dramSel), .expSel(expSel),
    .dramOffset(dramOffset), .expOffset(expOffset)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (addr %0h code %0d)", req, act, exp, accAddr, sizeCode);
    end
  endtask

  task automatic writeDis(input logic v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgExpDis = v;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgExpDis = ~v;
  endtask

  // Drive at negedge, sample 5 ns later, well before the next rising edge
  task automatic probe(input logic [31:0] a, input logic [3:0] code, input logic dis, input logic vld);
    logic [63:0] limit;
    logic inImg, eExp, eDram;
    string tag;
    @(negedge clk);
    accAddr = a; sizeCode = code; accValid = vld;
    #5;
    limit = 64'd1 << (int'(code) + 12);
    inImg = {32'd0, a} < limit;
    eExp  = vld && inImg && !dis && (code >= 4'hD) && a[24];
    eDram = vld && inImg && !eExp;
    tag = !vld ? "R6" : (!inImg ? "R3" : (eExp ? "R4" : "R5"));
    chk(tag, {63'd0, expSel}, {63'd0, eExp});
    chk(tag, {63'd0, dramSel}, {63'd0, eDram});
    chk("R7", {40'd0, expOffset}, eExp ? {40'd0, a[23:0]} : 64'd0);
    chk("R7", {32'd0, dramOffset}, eDram ? {32'd0, a} : 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state allows expansion on a large image
    probe(32'h0100_0040, 4'hD, 1'b0, 1'b1);
    probe(32'h0100_0040, 4'hF, 1'b0, 1'b1);
    for (int d = 0; d < 2; d++) begin
      writeDis(d[0]);
      for (int c = 0; c < 16; c++) begin
        for (int k = 0; k < 32; k++) begin
          probe(32'd1 << k, c[3:0], d[0], 1'b1);
          probe((32'd1 << k) - 32'd1, c[3:0], d[0], 1'b1);
          probe((32'd1 << k) | 32'h0100_0000, c[3:0], d[0], 1'b1);
          probe(32'h0155_AA55 ^ (32'd1 << k), c[3:0], d[0], 1'b0);
        end
      end
    end
    // R2: a write of 0 re-enables; no strobe leaves it unchanged
    writeDis(1'b1);
    probe(32'h0180_0000, 4'hE, 1'b1, 1'b1);
    writeDis(1'b0);
    probe(32'h0180_0000, 4'hE, 1'b0, 1'b1);
    @(negedge clk); cfgExpDis = 1'b1;
    repeat (2) @(negedge clk);
    probe(32'h01FF_FFFF, 4'hD, 1'b0, 1'b1);
    // R1: a second reset clears the disable bit again
    writeDis(1'b1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    probe(32'h0100_0000, 4'hD, 1'b0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule